// File: doc/BRIEF.md
# Multi-chip frame trigger sequencer

This block decides when one chip of a multi-chip radar starts each frame of a programmed burst. A controller issues commands on a small command port. The port carries a trigger opcode and a stop opcode, and the trigger carries the settings for the burst: mode, role, number of frames, frame period and sync pulse width. These settings are latched when the trigger is accepted.

In software mode, the trigger starts the first frame at once. Each later frame follows exactly one frame period after the previous one. In hardware mode, the trigger only arms the block. Each frame then waits for a rising edge on the synchronized sync input. A chip in the master role drives a pulse on its sync output every time it starts a frame. That pulse feeds the sync inputs of the other chips.

Every accepted trigger is acknowledged. The controller can therefore arm all slaves first and trigger the master only after that.

Top module: `frame_trig_seq`

## Requirements
- R1: After reset, `busy`, `frame_start`, `sync_out`, `cmd_ack` and `sync_err` are all 0.
- R2: A trigger is `cmd_valid` with `cmd_op`=1. When it is accepted while idle, `cmd_ack` pulses high for exactly one cycle, in the cycle after the command.
- R3: In software mode (`cmd_hw_mode`=0), the first `frame_start` is asserted in the same cycle as the acknowledge. Each later frame starts exactly `cmd_period` cycles after the previous one. A period of 0 is treated as 1.
- R4: A burst with `cmd_frames`=N (N>0) produces exactly N `frame_start` pulses. `busy` then falls to 0.
- R5: In hardware mode (`cmd_hw_mode`=1), the trigger only arms the block and starts no frame. Each frame starts 3 cycles after `sync_in` rises. One sync pulse starts exactly one frame.
- R6: In the master role (`cmd_master`=1), `sync_out` rises in the same cycle as `frame_start` and stays high for `cmd_sync_width` cycles. A width of 0 is treated as 1. In the slave role, `sync_out` stays 0.
- R7: A sync rising edge that arrives while the block is not waiting for one (idle or in a running frame) starts no frame. It sets `sync_err`, which holds until the next accepted trigger clears it.
- R8: A trigger received while `busy` is 1 is rejected. It gives no acknowledge.
- R9: `cmd_frames`=0 repeats frames without end. A stop command (`cmd_op`=2) lets the current frame finish and starts no further frame. It returns the block to idle, immediately if the block is armed and waiting for a sync edge.
- R10: `frame_start` is only asserted while `busy` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | 1 = trigger, 2 = stop |
| cmd_hw_mode | input | 1 | 1 = frames gated by sync input |
| cmd_master | input | 1 | 1 = drive sync output |
| cmd_frames | input | CNT_W | Frames per burst, 0 = endless |
| cmd_period | input | PER_W | Frame period in cycles |
| cmd_sync_width | input | PW_W | Sync output pulse width in cycles |
| sync_in | input | 1 | Asynchronous sync pulse input |
| sync_out | output | 1 | Sync pulse to other chips (master) |
| cmd_ack | output | 1 | One-cycle trigger acknowledge |
| frame_start | output | 1 | One-cycle frame start strobe |
| busy | output | 1 | Burst armed or running |
| sync_err | output | 1 | Sticky unexpected-sync flag |

## Verification
A wrong frame counter shows up within one burst: the count of `frame_start` pulses differs from the programmed number, or `busy` stays high or falls early. A wrong period counter moves the second frame start off its expected cycle, so it is visible one period after the trigger. A wrong state shows up on the next sync edge: the edge either starts a frame where none is allowed or sets `sync_err` where the edge should have been accepted. A width error on `sync_out` is seen at the first master frame.

// File: rtl/frame_trig_seq.sv
module frame_trig_seq #(
  parameter int CNT_W = 16,
  parameter int PER_W = 16,
  parameter int PW_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [1:0]       cmd_op,
  input  logic             cmd_hw_mode,
  input  logic             cmd_master,
  input  logic [CNT_W-1:0] cmd_frames,
  input  logic [PER_W-1:0] cmd_period,
  input  logic [PW_W-1:0]  cmd_sync_width,
  input  logic             sync_in,
  output logic             sync_out,
  output logic             cmd_ack,
  output logic             frame_start,
  output logic             busy,
  output logic             sync_err
);
  localparam logic [1:0] OP_TRIG = 2'd1;
  localparam logic [1:0] OP_STOP = 2'd2;

  typedef enum logic [1:0] {IDLE, ARMED, RUN} st_t;
  st_t st;

  logic             hw_q, master_q, stop_q;
  logic [CNT_W-1:0] frames_q, done;
  logic [PER_W-1:0] period_q, pcnt;
  logic [PW_W-1:0]  width_q, wcnt;
  logic [2:0]       sreg;

  wire rise     = sreg[1] & ~sreg[2];
  wire trig_ok  = cmd_valid && cmd_op == OP_TRIG && st == IDLE;
  wire stop_cmd = cmd_valid && cmd_op == OP_STOP;
  wire last     = pcnt == '0;
  wire more     = !stop_q && !stop_cmd && (frames_q == '0 || done < frames_q);

  wire start_now = (trig_ok && !cmd_hw_mode)
                || (st == ARMED && rise && !stop_cmd)
                || (st == RUN && last && more && !hw_q);

  wire             idle_src = st == IDLE;
  wire [PER_W-1:0] per_sel  = idle_src ? cmd_period : period_q;
  wire [PER_W-1:0] per_eff  = (per_sel == '0) ? PER_W'(1) : per_sel;
  wire [PW_W-1:0]  w_sel    = idle_src ? cmd_sync_width : width_q;
  wire [PW_W-1:0]  w_eff    = (w_sel == '0) ? PW_W'(1) : w_sel;
  wire             m_sel    = idle_src ? cmd_master : master_q;

  assign busy     = st != IDLE;
  assign sync_out = wcnt != '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= IDLE; sreg <= '0; hw_q <= 1'b0; master_q <= 1'b0; stop_q <= 1'b0;
      frames_q <= '0; done <= '0; period_q <= '0; pcnt <= '0;
      width_q <= '0; wcnt <= '0; cmd_ack <= 1'b0; frame_start <= 1'b0; sync_err <= 1'b0;
    end else begin
      sreg        <= {sreg[1:0], sync_in};
      cmd_ack     <= trig_ok;
      frame_start <= start_now;

      if (start_now) begin
        pcnt <= per_eff - PER_W'(1);
        done <= idle_src ? CNT_W'(1) : done + CNT_W'(1);
        wcnt <= m_sel ? w_eff : '0;
      end else if (wcnt != '0) begin
        wcnt <= wcnt - PW_W'(1);
      end

      case (st)
        IDLE: if (trig_ok) begin
          hw_q <= cmd_hw_mode; master_q <= cmd_master; frames_q <= cmd_frames;
          period_q <= cmd_period; width_q <= cmd_sync_width;
          stop_q <= 1'b0; sync_err <= 1'b0;
          if (!cmd_hw_mode) done <= CNT_W'(1);
          else done <= '0;
          st <= cmd_hw_mode ? ARMED : RUN;
        end
        ARMED: if (stop_cmd) st <= IDLE;
               else if (rise) st <= RUN;
        RUN: begin
          if (stop_cmd) stop_q <= 1'b1;
          if (last) begin
            if (!more) st <= IDLE;
            else if (hw_q) st <= ARMED;
          end else begin
            pcnt <= pcnt - PER_W'(1);
          end
        end
        default: st <= IDLE;
      endcase

      if (rise && st != ARMED) sync_err <= 1'b1;
    end
  end
endmodule

module frame_trig_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic cmd_ack,
  input logic frame_start,
  input logic busy,
  input logic sync_out,
  input logic sync_err
);
  a_r2_ack_single: assert property (@(posedge clk) disable iff (!rst_n) cmd_ack |=> !cmd_ack);
  a_r2_ack_busy:   assert property (@(posedge clk) disable iff (!rst_n) cmd_ack |-> busy);
  a_r10_fs_busy:   assert property (@(posedge clk) disable iff (!rst_n) frame_start |-> busy);
  a_r6_sync_align: assert property (@(posedge clk) disable iff (!rst_n) $rose(sync_out) |-> frame_start);
  a_r7_err_clear:  assert property (@(posedge clk) disable iff (!rst_n) $fell(sync_err) |-> cmd_ack);
endmodule

bind frame_trig_seq frame_trig_seq_chk chk_i (
  .clk(clk), .rst_n(rst_n), .cmd_ack(cmd_ack), .frame_start(frame_start),
  .busy(busy), .sync_out(sync_out), .sync_err(sync_err)
);

// File: tb/frame_trig_seq_tb.sv
module frame_trig_seq_tb_top;
  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0, cmd_hw_mode = 0, cmd_master = 0, sync_in = 0;
  logic [1:0]  cmd_op = 0;
  logic [15:0] cmd_frames = 0, cmd_period = 0;
  logic [3:0]  cmd_sync_width = 0;
  logic sync_out, cmd_ack, frame_start, busy, sync_err;
  int errors = 0, checks = 0;
  int cyc = 0, fs_n = 0, so_n = 0, ack_n = 0;
  int fs_cyc[16];

  always #5 clk = ~clk;

  frame_trig_seq dut_i (.*);

  always @(negedge clk) begin
    cyc++;
    if (frame_start) begin fs_cyc[fs_n % 16] = cyc; fs_n++; end
    if (sync_out) so_n++;
    if (cmd_ack) ack_n++;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin errors++; $display("FAIL %s actual=%0d expected=%0d", req, act, exp); end
  endtask

  task automatic clr(); fs_n = 0; so_n = 0; ack_n = 0; endtask

  task automatic cmd(input int op, input bit hw, input bit m, input int n, input int p, input int w);
    @(negedge clk);
    cmd_valid = 1; cmd_op = 2'(op); cmd_hw_mode = hw; cmd_master = m;
    cmd_frames = 16'(n); cmd_period = 16'(p); cmd_sync_width = 4'(w);
    @(negedge clk);
    cmd_valid = 0; cmd_op = 0;
  endtask

  task automatic pulse();
    @(negedge clk); sync_in = 1;
    repeat (3) @(negedge clk);
    sync_in = 0;
  endtask

  task automatic t_reset();
    check(!busy && !frame_start && !sync_out && !cmd_ack && !sync_err, "R1",
          {busy, frame_start, sync_out, cmd_ack, sync_err}, 0);
  endtask

  task automatic t_sw_burst();
    clr();
    cmd(1, 0, 1, 3, 5, 4);
    check(cmd_ack == 1, "R2 ack", cmd_ack, 1);
    check(frame_start == 1, "R3 first start with ack", frame_start, 1);
    check(sync_out == 1, "R6 sync_out with start", sync_out, 1);
    @(negedge clk);
    check(cmd_ack == 0, "R2 ack one cycle", cmd_ack, 0);
    repeat (20) @(negedge clk);
    check(fs_n == 3, "R4 frame count", fs_n, 3);
    check(fs_cyc[1] - fs_cyc[0] == 5, "R3 period", fs_cyc[1] - fs_cyc[0], 5);
    check(fs_cyc[2] - fs_cyc[1] == 5, "R3 period", fs_cyc[2] - fs_cyc[1], 5);
    check(so_n == 12, "R6 pulse width 4 per frame", so_n, 12);
    check(busy == 0, "R4 idle after burst", busy, 1'b0);
  endtask

  task automatic t_hw_slave();
    clr();
    cmd(1, 1, 0, 2, 20, 4);
    check(cmd_ack == 1 && busy == 1, "R5 armed", {cmd_ack, busy}, 3);
    repeat (10) @(negedge clk);
    check(fs_n == 0, "R5 no frame before sync", fs_n, 0);
    cmd(1, 0, 1, 1, 5, 4);
    check(cmd_ack == 0 && ack_n == 1, "R8 trigger while busy rejected", ack_n, 1);
    pulse();
    repeat (2) @(negedge clk);
    check(fs_n == 1, "R5 one pulse one frame", fs_n, 1);
    pulse();
    repeat (2) @(negedge clk);
    check(fs_n == 1, "R7 sync during frame ignored", fs_n, 1);
    check(sync_err == 1, "R7 err set", sync_err, 1);
    repeat (25) @(negedge clk);
    check(busy == 1 && fs_n == 1, "R5 waits for second sync", fs_n, 1);
    pulse();
    repeat (25) @(negedge clk);
    check(fs_n == 2 && busy == 0, "R4 hw burst ends", fs_n, 2);
    check(so_n == 0, "R6 slave sync_out low", so_n, 0);
    check(sync_err == 1, "R7 err sticky", sync_err, 1);
  endtask

  task automatic t_idle_sync();
    int n0;
    clr();
    pulse();
    repeat (3) @(negedge clk);
    check(fs_n == 0 && busy == 0, "R7 idle sync starts nothing", fs_n, 0);
    check(sync_err == 1, "R7 idle sync sets err", sync_err, 1);
    cmd(1, 0, 0, 1, 3, 0);
    check(sync_err == 0, "R7 err cleared by trigger", sync_err, 0);
    repeat (6) @(negedge clk);
    n0 = fs_n;
    check(n0 == 1 && so_n == 0, "R6 slave sw no sync_out", so_n, 0);
  endtask

  task automatic t_width0_master();
    clr();
    cmd(1, 0, 1, 1, 0, 0);
    repeat (5) @(negedge clk);
    check(so_n == 1 && fs_n == 1, "R6 width 0 as 1", so_n, 1);
    check(busy == 0, "R3 period 0 as 1", busy, 0);
  endtask

  task automatic t_endless_stop();
    int n0;
    clr();
    cmd(1, 0, 0, 0, 4, 2);
    repeat (20) @(negedge clk);
    check(fs_n >= 5 && busy == 1, "R9 endless", fs_n, 5);
    cmd(2, 0, 0, 0, 0, 0);
    n0 = fs_n;
    repeat (10) @(negedge clk);
    check(fs_n == n0, "R9 no frame after stop", fs_n, n0);
    check(busy == 0, "R9 idle after stop", busy, 0);
    clr();
    cmd(1, 1, 0, 0, 4, 2);
    cmd(2, 0, 0, 0, 0, 0);
    check(busy == 0, "R9 stop while armed", busy, 0);
    pulse();
    repeat (3) @(negedge clk);
    check(fs_n == 0, "R9 no frame after armed stop", fs_n, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_sw_burst();
    t_hw_slave();
    t_idle_sync();
    t_width0_master();
    t_endless_stop();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #200000;
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule